// File: doc/BRIEF.md
# Packet Buffer Page Queue Manager

This block keeps track of the pages of an on-board packet memory cut into 2 KB pages. The pages are handled as tokens, which are page numbers. Four hardware queues carry these tokens:

- a free-page queue;
- a transmit queue;
- a transmit-completion queue;
- a receive queue.

Frame bytes are stored elsewhere. This block only decides which page is owned by whom.

A host reaches every queue through a small register port. Reading a queue's port register pops its head, writing it pushes a page, and a separate register reports each queue's occupancy. A MAC-side stub interface stands in for the network engine:

- It sees the head of the transmit queue. Each completion it reports moves that page, together with its collision and carrier status, into the completion queue.
- Each frame arrival takes the head of the free queue and places it on the receive queue.

Two level flags tell the host that received pages or completion entries are waiting.

Two small combinational helpers fix the layouts that software and the engine share:

- a builder for the 4-byte header at the start of a transmit page;
- a decoder for the status word at the start of a receive page.

Page 0 is never handed out. It is the "nothing available" answer. The number of pages is set at build time by a memory-size option.

Top module: `pgq_mgr`

## Requirements
- R1: After reset the free queue holds pages 1 up to the last page in ascending order. The last page is 63 when LARGE_MEM=0 and 127 when LARGE_MEM=1. The free count equals the last page, and all other counts are 0.
- R2: A host read of address 0 pops the free queue and returns the page in host_rdata_o[7:0] on the cycle after the read. When the free queue is empty, the read returns 0 and the count stays 0.
- R3: While mac_rx_stall_o is low, mac_rx_push_i moves the free-queue head (shown on mac_rx_page_o) onto the receive queue. mac_rx_stall_o is high when the free queue is empty or when the host reads address 0 in the same cycle. A push while stalled changes nothing.
- R4: A host write to address 2 appends host_wdata_i to the transmit queue while its count is below TX_MAX (16). A write at the limit is dropped.
- R5: A host write to address 0 returns a page to the free queue. A push to any full queue is dropped and sets a sticky overflow bit, cleared only by reset. The bits are read at address 7: bit0 free, bit1 transmit, bit2 completion, bit3 receive.
- R6: mac_tx_valid_o and mac_tx_page_o present the transmit-queue head in push order. mac_tx_done_i pops that head and appends one completion entry.
- R7: A host read of address 3 pops a completion entry with the following fields:
  - [7:0] the page;
  - [8] late collision;
  - [9] no carrier;
  - [11:10] collision count (00 means none, 11 means excessive);
  - [12] failed, set for late collision, no carrier or excessive collisions;
  - [13] sent after collisions, set when the count is nonzero and the entry has not failed.
  mac_tx_stat_i uses the same layout as bits [11:8].
- R8: rx_ne_o is high exactly while the receive count is nonzero. txd_ne_o is high exactly while the completion count is nonzero.
- R9: A host read of address 5 pops receive pages in arrival order and returns 0 when the receive queue is empty.
- R10: tx_hdr_o packs four bytes, from bits [7:0] upward: the control byte, the length low byte, the length high byte, and the data offset 4.
- R11: From rx_stat_i, rx_ok_o is bit 0. rx_len_o is bits [18:8] minus 4 for the FCS, and saturates at 0.
- R12: The counts are read at addresses 1 (free), 2 (transmit), 4 (completion) and 6 (receive), and a read of any of them leaves the queues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_addr_i | input | 3 | Host register address |
| host_we_i | input | 1 | Host write strobe |
| host_re_i | input | 1 | Host read strobe |
| host_wdata_i | input | PW | Page written by the host |
| host_rdata_o | output | 16 | Registered read data |
| rx_ne_o | output | 1 | Receive queue not empty |
| txd_ne_o | output | 1 | Completion queue not empty |
| mac_tx_valid_o | output | 1 | Transmit page waiting |
| mac_tx_page_o | output | PW | Transmit-queue head page |
| mac_tx_done_i | input | 1 | Engine finished the head page |
| mac_tx_stat_i | input | 4 | Completion status of that page |
| mac_rx_push_i | input | 1 | Frame arrived, take a free page |
| mac_rx_stall_o | output | 1 | No free page can be taken now |
| mac_rx_page_o | output | PW | Page the next arrival will use |
| tx_ctl_i | input | 8 | Transmit control byte |
| tx_len_i | input | 16 | Transmit frame length |
| tx_hdr_o | output | 32 | Transmit page header |
| rx_stat_i | input | 32 | Receive page status word |
| rx_ok_o | output | 1 | Good frame flag |
| rx_len_o | output | 11 | Frame length without FCS |

## Verification
The hardest situations to reach are the free queue being pushed while it is full, and the free queue being read out right across its wrap point. Both occur only after pages have left and some of them have come back.

The bench first takes pages out through host pops and engine arrivals. It then returns six pages, which pushes the write pointer past the array end, adds one extra page to provoke the drop, and drains all 63 entries, so that the order across the wrap is checked entry by entry. The cycle in which a host pop and an engine arrival compete for the same head is driven explicitly, in one clock.

// File: rtl/pgq_pkg.sv
package pgq_pkg;
  localparam int DW          = 16;
  localparam int TX_DATA_OFS = 4;
  localparam int FCS_BYTES   = 4;

  typedef enum logic [2:0] {
    A_FREE     = 3'd0,
    A_FREE_CNT = 3'd1,
    A_TXQ      = 3'd2,
    A_DONE     = 3'd3,
    A_DONE_CNT = 3'd4,
    A_RXQ      = 3'd5,
    A_RX_CNT   = 3'd6,
    A_OVF      = 3'd7
  } reg_addr_e;

  typedef struct packed {
    logic [1:0] col;
    logic       no_carrier;
    logic       late_col;
  } tx_stat_t;

  function automatic logic txd_failed(tx_stat_t s);
    return s.late_col | s.no_carrier | (s.col == 2'b11);
  endfunction
endpackage

// File: rtl/pgq_fifo.sv
module pgq_fifo #(
  parameter int W        = 7,
  parameter int DEPTH    = 64,
  parameter int LIMIT    = 63,
  parameter int INIT_CNT = 0,
  localparam int AW      = $clog2(DEPTH),
  localparam int CW      = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic [W-1:0]  head_o,
  output logic [CW-1:0] cnt_o,
  output logic          ovf_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic          full, push_ok, pop_ok;

  assign full    = (cnt_o == CW'(LIMIT));
  assign push_ok = push_i && !full;
  assign pop_ok  = pop_i && (cnt_o != '0);
  assign head_o  = (cnt_o == '0) ? '0 : mem[rd_ptr];

  function automatic logic [AW-1:0] inc(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      // preloaded contents: entry i holds token i+1
      for (int i = 0; i < DEPTH; i++) mem[i] <= (i < INIT_CNT) ? W'(i + 1) : '0;
      rd_ptr <= '0;
      wr_ptr <= AW'(INIT_CNT % DEPTH);
      cnt_o  <= CW'(INIT_CNT);
      ovf_o  <= 1'b0;
    end else begin
      if (push_ok) begin
        mem[wr_ptr] <= data_i;
        wr_ptr      <= inc(wr_ptr);
      end
      if (pop_ok) rd_ptr <= inc(rd_ptr);
      cnt_o <= cnt_o + CW'(push_ok) - CW'(pop_ok);
      if (push_i && full) ovf_o <= 1'b1;
    end
  end

  a_r5_cnt_in_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o <= CW'(LIMIT));
  a_r5_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);
  a_r5_drop_keeps_cnt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full && !pop_i) |=> (cnt_o == $past(cnt_o)));
  a_r2_push_grows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_ok && !pop_ok) |=> (cnt_o == $past(cnt_o) + 1'b1));
endmodule

// File: rtl/pgq_hdr.sv
module pgq_hdr
  import pgq_pkg::*;
(
  input  logic [7:0]  tx_ctl_i,
  input  logic [15:0] tx_len_i,
  output logic [31:0] tx_hdr_o,
  input  logic [31:0] rx_stat_i,
  output logic        rx_ok_o,
  output logic [10:0] rx_len_o
);
  logic [10:0] raw_len;
  logic        unused_bits;

  assign tx_hdr_o    = {8'(TX_DATA_OFS), tx_len_i[15:8], tx_len_i[7:0], tx_ctl_i};
  assign raw_len     = rx_stat_i[18:8];
  assign rx_ok_o     = rx_stat_i[0];
  // length field counts the FCS; strip it, never wrap below zero
  assign rx_len_o    = (raw_len < 11'(FCS_BYTES)) ? '0 : raw_len - 11'(FCS_BYTES);
  assign unused_bits = ^{rx_stat_i[31:19], rx_stat_i[7:1]};
endmodule

// File: rtl/pgq_mgr.sv
module pgq_mgr
  import pgq_pkg::*;
#(
  parameter int  LARGE_MEM = 0,
  parameter int  TX_MAX    = 16,
  localparam int LAST_PAGE = (LARGE_MEM != 0) ? 127 : 63,
  localparam int PW        = $clog2(LAST_PAGE + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    host_addr_i,
  input  logic          host_we_i,
  input  logic          host_re_i,
  input  logic [PW-1:0] host_wdata_i,
  output logic [15:0]   host_rdata_o,
  output logic          rx_ne_o,
  output logic          txd_ne_o,
  output logic          mac_tx_valid_o,
  output logic [PW-1:0] mac_tx_page_o,
  input  logic          mac_tx_done_i,
  input  logic [3:0]    mac_tx_stat_i,
  input  logic          mac_rx_push_i,
  output logic          mac_rx_stall_o,
  output logic [PW-1:0] mac_rx_page_o,
  input  logic [7:0]    tx_ctl_i,
  input  logic [15:0]   tx_len_i,
  output logic [31:0]   tx_hdr_o,
  input  logic [31:0]   rx_stat_i,
  output logic          rx_ok_o,
  output logic [10:0]   rx_len_o
);
  localparam int PG_CW = $clog2(LAST_PAGE + 2);
  localparam int TX_CW = $clog2(TX_MAX + 1);
  localparam int EW    = PW + 4;

  logic [PW-1:0]    free_head, rx_head, tx_head;
  logic [EW-1:0]    done_head;
  logic [PG_CW-1:0] free_cnt, rx_cnt;
  logic [TX_CW-1:0] tx_cnt, done_cnt;
  logic [3:0]       ovf;
  logic             host_pop_free, host_pop_rx, host_pop_done;
  logic             host_push_free, host_push_tx, rx_take, tx_pop;
  tx_stat_t         done_stat;
  logic [DW-1:0]    rdata_q;

  assign host_pop_free  = host_re_i && (host_addr_i == A_FREE);
  assign host_pop_rx    = host_re_i && (host_addr_i == A_RXQ);
  assign host_pop_done  = host_re_i && (host_addr_i == A_DONE);
  assign host_push_free = host_we_i && (host_addr_i == A_FREE);
  assign host_push_tx   = host_we_i && (host_addr_i == A_TXQ);

  // host read of the free port wins the head; the engine retries
  assign mac_rx_stall_o = (free_cnt == '0) || host_pop_free;
  assign rx_take        = mac_rx_push_i && !mac_rx_stall_o;
  assign mac_rx_page_o  = free_head;
  assign tx_pop         = mac_tx_done_i && (tx_cnt != '0);
  assign mac_tx_valid_o = (tx_cnt != '0);
  assign mac_tx_page_o  = tx_head;
  assign rx_ne_o        = (rx_cnt != '0);
  assign txd_ne_o       = (done_cnt != '0);

  pgq_fifo #(.W(PW), .DEPTH(LAST_PAGE + 1), .LIMIT(LAST_PAGE), .INIT_CNT(LAST_PAGE)) u_free (
    .clk_i, .rst_ni, .push_i(host_push_free), .data_i(host_wdata_i),
    .pop_i(host_pop_free || rx_take), .head_o(free_head), .cnt_o(free_cnt), .ovf_o(ovf[0]));

  pgq_fifo #(.W(PW), .DEPTH(TX_MAX), .LIMIT(TX_MAX), .INIT_CNT(0)) u_txq (
    .clk_i, .rst_ni, .push_i(host_push_tx), .data_i(host_wdata_i),
    .pop_i(tx_pop), .head_o(tx_head), .cnt_o(tx_cnt), .ovf_o(ovf[1]));

  pgq_fifo #(.W(EW), .DEPTH(TX_MAX), .LIMIT(TX_MAX), .INIT_CNT(0)) u_done (
    .clk_i, .rst_ni, .push_i(tx_pop), .data_i({mac_tx_stat_i, tx_head}),
    .pop_i(host_pop_done), .head_o(done_head), .cnt_o(done_cnt), .ovf_o(ovf[2]));

  pgq_fifo #(.W(PW), .DEPTH(LAST_PAGE + 1), .LIMIT(LAST_PAGE), .INIT_CNT(0)) u_rxq (
    .clk_i, .rst_ni, .push_i(rx_take), .data_i(free_head),
    .pop_i(host_pop_rx), .head_o(rx_head), .cnt_o(rx_cnt), .ovf_o(ovf[3]));

  pgq_hdr u_hdr (
    .tx_ctl_i, .tx_len_i, .tx_hdr_o, .rx_stat_i, .rx_ok_o, .rx_len_o);

  assign done_stat = tx_stat_t'(done_head[EW-1:PW]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (host_re_i) begin
      unique case (host_addr_i)
        A_FREE:     rdata_q <= DW'(free_head);
        A_FREE_CNT: rdata_q <= DW'(free_cnt);
        A_TXQ:      rdata_q <= DW'(tx_cnt);
        A_DONE:     rdata_q <= {2'b00,
                                (done_stat.col != 2'b00) && !txd_failed(done_stat),
                                txd_failed(done_stat), done_stat, 8'(done_head[PW-1:0])};
        A_DONE_CNT: rdata_q <= DW'(done_cnt);
        A_RXQ:      rdata_q <= DW'(rx_head);
        A_RX_CNT:   rdata_q <= DW'(rx_cnt);
        A_OVF:      rdata_q <= DW'(ovf);
        default:    rdata_q <= '0;
      endcase
    end
  end
  assign host_rdata_o = rdata_q;

  a_r2_empty_pop_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_pop_free && free_cnt == '0) |=> (host_rdata_o == '0));
  a_r3_stall_keeps_rx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mac_rx_push_i && mac_rx_stall_o && !host_pop_rx) |=> (rx_cnt == $past(rx_cnt)));
  a_r4_tx_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_cnt <= TX_CW'(TX_MAX));
  a_r6_done_raises_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mac_tx_done_i && mac_tx_valid_o) |=> txd_ne_o);
  a_r8_rx_flag_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_pop_rx && rx_cnt == PG_CW'(1) && !rx_take) |=> !rx_ne_o);
endmodule

// File: tb/pgq_mgr_bench.sv
module pgq_mgr_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [5:0]  wdata = '0;
  logic [15:0] rdata;
  logic        rx_ne, txd_ne, tx_valid, tx_done = 1'b0, rx_push = 1'b0, rx_stall;
  logic [5:0]  tx_page, rx_page;
  logic [3:0]  tx_stat = '0;
  logic [7:0]  tx_ctl = '0;
  logic [15:0] tx_len = '0;
  logic [31:0] tx_hdr, rx_stat = '0;
  logic        rx_ok;
  logic [10:0] rx_len;

  logic [2:0]  l_addr = '0;
  logic        l_re = 1'b0;
  logic [15:0] l_rdata;
  logic [6:0]  l_rx_page, l_tx_page;
  logic        l_rx_ne, l_txd_ne, l_tx_valid, l_rx_stall, l_rx_ok;
  logic [31:0] l_tx_hdr;
  logic [10:0] l_rx_len;

  pgq_mgr u_pgq_mgr (
    .clk_i(clk), .rst_ni(rst_n), .host_addr_i(addr), .host_we_i(we), .host_re_i(re),
    .host_wdata_i(wdata), .host_rdata_o(rdata), .rx_ne_o(rx_ne), .txd_ne_o(txd_ne),
    .mac_tx_valid_o(tx_valid), .mac_tx_page_o(tx_page), .mac_tx_done_i(tx_done),
    .mac_tx_stat_i(tx_stat), .mac_rx_push_i(rx_push), .mac_rx_stall_o(rx_stall),
    .mac_rx_page_o(rx_page), .tx_ctl_i(tx_ctl), .tx_len_i(tx_len), .tx_hdr_o(tx_hdr),
    .rx_stat_i(rx_stat), .rx_ok_o(rx_ok), .rx_len_o(rx_len));

  pgq_mgr #(.LARGE_MEM(1)) u_pgq_mgr_large (
    .clk_i(clk), .rst_ni(rst_n), .host_addr_i(l_addr), .host_we_i(1'b0), .host_re_i(l_re),
    .host_wdata_i(7'd0), .host_rdata_o(l_rdata), .rx_ne_o(l_rx_ne), .txd_ne_o(l_txd_ne),
    .mac_tx_valid_o(l_tx_valid), .mac_tx_page_o(l_tx_page), .mac_tx_done_i(1'b0),
    .mac_tx_stat_i(4'd0), .mac_rx_push_i(1'b0), .mac_rx_stall_o(l_rx_stall),
    .mac_rx_page_o(l_rx_page), .tx_ctl_i(8'd0), .tx_len_i(16'd0), .tx_hdr_o(l_tx_hdr),
    .rx_stat_i(32'd0), .rx_ok_o(l_rx_ok), .rx_len_o(l_rx_len));

  int total = 0, bad = 0;
  int exp_q[$];
  string tag_q[$];
  logic rd_seen = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: compare each registered read result with the scoreboard head
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      int e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(rdata == e[15:0], t, int'(rdata), e);
    end
    rd_seen = re;
  end

  task automatic rd(input logic [2:0] a, input int e, input string t);
    @(posedge clk); #1;
    addr = a; re = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(posedge clk); #1;
    re = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    @(posedge clk); #1;
    addr = a; we = 1'b1; wdata = 6'(d);
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic mac_done(input logic [3:0] s);
    @(posedge clk); #1;
    tx_done = 1'b1; tx_stat = s;
    @(posedge clk); #1;
    tx_done = 1'b0;
  endtask

  task automatic mac_rx();
    @(posedge clk); #1;
    rx_push = 1'b1;
    @(posedge clk); #1;
    rx_push = 1'b0;
  endtask

  task automatic lrd(input logic [2:0] a, input int e, input string t);
    @(posedge clk); #1;
    l_addr = a; l_re = 1'b1;
    @(posedge clk); #1;
    l_re = 1'b0;
    @(negedge clk);
    chk(l_rdata == e[15:0], t, int'(l_rdata), e);
  endtask

  task automatic finish_run();
    repeat (3) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(rx_ne == 1'b0, "R1/R8 rx_ne after reset", rx_ne, 0);
    chk(txd_ne == 1'b0, "R1/R8 txd_ne after reset", txd_ne, 0);
    chk(tx_valid == 1'b0, "R1 tx_valid after reset", tx_valid, 0);
    chk(rx_page == 6'd1, "R1 first free page", rx_page, 1);
    chk(rx_stall == 1'b0, "R3 no stall after reset", rx_stall, 0);
    rd(3'd1, 63, "R1/R12 free count");
    rd(3'd2, 0, "R1/R12 tx count");
    rd(3'd4, 0, "R1/R12 done count");
    rd(3'd6, 0, "R1/R12 rx count");
    rd(3'd7, 0, "R1/R5 overflow bits");
    lrd(3'd1, 127, "R1 large free count");
    lrd(3'd0, 1, "R1 large first pop");
    lrd(3'd0, 2, "R1 large second pop");
    chk(l_rx_page == 7'd3, "R1 large next page", l_rx_page, 3);

    // R2 ordered free pops
    rd(3'd0, 1, "R2 pop 1");
    rd(3'd0, 2, "R2 pop 2");
    rd(3'd0, 3, "R2 pop 3");
    rd(3'd1, 60, "R2/R12 free count after pops");

    // R6/R7 transmit path
    wr(3'd2, 1);
    wr(3'd2, 2);
    @(negedge clk);
    chk(tx_valid && tx_page == 6'd1, "R6 head page 1", tx_page, 1);
    rd(3'd2, 2, "R4/R12 tx count 2");
    mac_done(4'b0000);
    @(negedge clk);
    chk(tx_page == 6'd2, "R6 head page 2", tx_page, 2);
    chk(txd_ne == 1'b1, "R8 txd_ne raised", txd_ne, 1);
    mac_done(4'b1100);
    wr(3'd2, 3);
    mac_done(4'b0110);
    wr(3'd2, 7);
    mac_done(4'b0100);
    @(negedge clk);
    chk(tx_valid == 1'b0, "R6 tx queue drained", tx_valid, 0);
    rd(3'd4, 4, "R12 done count 4");
    rd(3'd3, 32'h0001, "R7 clean entry");
    rd(3'd3, 32'h1C02, "R7 excessive collisions");
    rd(3'd3, 32'h1603, "R7 no carrier");
    rd(3'd3, 32'h2407, "R7 sent after collisions");
    @(negedge clk);
    chk(txd_ne == 1'b0, "R8 txd_ne cleared", txd_ne, 0);

    // R3/R9 receive path
    @(negedge clk);
    chk(rx_page == 6'd4, "R3 arrival page 4", rx_page, 4);
    mac_rx();
    mac_rx();
    @(negedge clk);
    chk(rx_ne == 1'b1, "R8 rx_ne raised", rx_ne, 1);
    rd(3'd6, 2, "R3/R12 rx count 2");
    rd(3'd1, 58, "R3 free count 58");
    rd(3'd5, 4, "R9 rx pop 4");
    rd(3'd5, 5, "R9 rx pop 5");
    rd(3'd5, 0, "R9 rx empty returns 0");
    @(negedge clk);
    chk(rx_ne == 1'b0, "R8 rx_ne cleared", rx_ne, 0);

    // R3 contention: host pop and arrival in the same cycle
    @(posedge clk); #1;
    addr = 3'd0; re = 1'b1; rx_push = 1'b1;
    exp_q.push_back(6); tag_q.push_back("R3 host wins page 6");
    @(negedge clk);
    chk(rx_stall == 1'b1, "R3 stall during host pop", rx_stall, 1);
    @(posedge clk); #1;
    re = 1'b0; rx_push = 1'b0;
    rd(3'd6, 0, "R3 stalled arrival dropped");

    // R4 transmit limit
    for (int i = 0; i < 16; i++) wr(3'd2, 10 + i);
    rd(3'd2, 16, "R4 tx count at limit");
    wr(3'd2, 26);
    rd(3'd2, 16, "R4 push at limit dropped");
    rd(3'd7, 2, "R5 tx overflow bit");
    @(negedge clk);
    chk(tx_page == 6'd10, "R6 head unchanged by drop", tx_page, 10);

    // R5 free refill past the wrap, then overflow
    for (int i = 1; i <= 6; i++) wr(3'd0, i);
    rd(3'd1, 63, "R5 free full");
    wr(3'd0, 9);
    rd(3'd1, 63, "R5 free push dropped");
    rd(3'd7, 3, "R5 free overflow bit, tx bit sticky");

    // R2 full drain across the wrap
    for (int i = 7; i <= 63; i++) rd(3'd0, i, "R2 drain order");
    for (int i = 1; i <= 6; i++) rd(3'd0, i, "R2 drain wrapped order");
    rd(3'd0, 0, "R2 empty sentinel");
    rd(3'd1, 0, "R2 free count 0");
    @(negedge clk);
    chk(rx_stall == 1'b1, "R3 stall when free empty", rx_stall, 1);
    mac_rx();
    rd(3'd6, 0, "R3 arrival with no page dropped");

    // R10/R11 header helpers
    @(posedge clk); #1;
    tx_ctl = 8'hA5; tx_len = 16'h05EA; rx_stat = 32'h0000_4001;
    @(negedge clk);
    chk(tx_hdr == 32'h0405_EAA5, "R10 tx header", tx_hdr, 32'h0405_EAA5);
    chk(rx_ok == 1'b1 && rx_len == 11'd60, "R11 good frame length", rx_len, 60);
    @(posedge clk); #1;
    rx_stat = 32'h0000_0200;
    @(negedge clk);
    chk(rx_ok == 1'b0 && rx_len == 11'd0, "R11 length saturates", rx_len, 0);
    @(posedge clk); #1;
    rx_stat = 32'h0007_FF01;
    @(negedge clk);
    chk(rx_len == 11'h7FB, "R11 max length", rx_len, 11'h7FB);

    finish_run();
  end
endmodule